// File: doc/BRIEF.md
# Range-Based DMA Address Translator

This block sits between a burst DMA engine and memory. It converts each burst's virtual start address into a physical address. It uses a small table of contiguous ranges rather than pages. Each table slot holds a valid flag, a virtual base, a physical base and a byte size. A request is one whole burst. It gives the start address and the offset of the burst's last byte. The block returns one response per burst: a physical address and a fault code.

Tensor traffic tends to walk through memory in order. For that reason the block keeps a cursor on the slot that served the last successful translation, and it tries that slot first. When the cursor slot does not match, the block walks the other slots one per cycle, starting after the cursor and wrapping around. The first slot that matches ends the walk. Only a privileged configuration port can change the table. Any privileged write drops the cursor.

Top module: `range_xlate`

## Requirements
- R1: After reset `rsp_valid_o` is 0, `req_ready_o` is 1, every slot is invalid and the cursor is empty. The first request after reset therefore walks the table from slot 0.
- R2: A slot matches address va when its valid flag is 1 and vbase <= va < vbase + size. A successful response returns pbase + (va - vbase) with fault code 2'b00.
- R3: If the cursor is set and its slot matches the request, the response is valid in the cycle right after the accepting clock edge (latency 1).
- R4: On a cursor miss, slots are checked one per cycle. The walk starts at cursor+1 and wraps from the last slot to slot 0; with no cursor it starts at slot 0. If k slots are checked, the response arrives 1+k cycles after acceptance. A successful walk moves the cursor to the matching slot.
- R5: When no slot matches, the response carries fault code 2'b01 and physical address 0. This happens after all N-1 other slots have been checked, or after all N slots when there is no cursor. The cursor is left unchanged.
- R6: When the start address matches a slot but (va - vbase) + last >= size, the response carries fault code 2'b10 and physical address 0. In that case the cursor does not move. A burst whose last byte is exactly the range's final byte succeeds.
- R7: A table write with `cfg_priv_i` low changes neither the table nor the cursor.
- R8: A table write with `cfg_priv_i` high stores the slot and empties the cursor.
- R9: `req_ready_o` is low while a walk is in progress. Each response follows exactly one accepted request.
- R10: A slot whose valid flag is 0 never matches, whatever its bases and size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_priv_i | input | 1 | Write comes from the privileged context |
| cfg_idx_i | input | IDX_W (4) | Slot index to write |
| cfg_valid_i | input | 1 | Valid flag for the written slot |
| cfg_vbase_i | input | ADDR_W (48) | Virtual base |
| cfg_pbase_i | input | ADDR_W (48) | Physical base |
| cfg_size_i | input | ADDR_W (48) | Range size in bytes |
| req_valid_i | input | 1 | Burst request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_va_i | input | ADDR_W (48) | Virtual start address of the burst |
| req_last_i | input | LEN_W (16) | Byte offset of the burst's last byte from its start |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_pa_o | output | ADDR_W (48) | Translated physical address (0 on fault) |
| rsp_fault_o | output | 2 | 00 ok, 01 no match, 10 burst crosses range end |

## Verification
The embedded properties check several things on every cycle:
- a cursor match always answers in the next cycle;
- the walk counter stays within the table size;
- a successful walk leaves the cursor on the slot that matched;
- a privileged write always empties the cursor;
- an unprivileged write leaves every slot unchanged;
- every response is traceable to an accepted request or an active walk.

Other properties are shown only by the directed scenarios:
- the exact walk latencies for the wrap-around starting points;
- the translated address values;
- the boundary where the last byte sits exactly at the end of a range;
- that a failed walk leaves the cursor alone.

// File: rtl/range_xlate_pkg.sv
package range_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_OK    = 2'b00,
    FLT_NOHIT = 2'b01,
    FLT_CROSS = 2'b10
  } fault_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } state_e;
endpackage

// File: rtl/range_xlate_table.sv
module range_xlate_table #(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ADDR_W      = 48,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_priv_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_vbase_i,
  input  logic [ADDR_W-1:0] wr_pbase_i,
  input  logic [ADDR_W-1:0] wr_size_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output logic              rd_a_valid_o,
  output logic [ADDR_W-1:0] rd_a_vbase_o,
  output logic [ADDR_W-1:0] rd_a_pbase_o,
  output logic [ADDR_W-1:0] rd_a_size_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output logic              rd_b_valid_o,
  output logic [ADDR_W-1:0] rd_b_vbase_o,
  output logic [ADDR_W-1:0] rd_b_pbase_o,
  output logic [ADDR_W-1:0] rd_b_size_o
);
  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] vbase;
    logic [ADDR_W-1:0] pbase;
    logic [ADDR_W-1:0] size;
  } slot_t;

  slot_t slot_q [NUM_ENTRIES];
  logic  wr_ok;

  assign wr_ok = wr_en_i && wr_priv_i;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[i] <= '0;
      end else if (wr_ok && (wr_idx_i == IDX_W'(i))) begin
        slot_q[i].valid <= wr_valid_i;
        slot_q[i].vbase <= wr_vbase_i;
        slot_q[i].pbase <= wr_pbase_i;
        slot_q[i].size  <= wr_size_i;
      end
    end

    // R7: unprivileged writes leave the slot untouched
    p_unpriv_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_priv_i) |=> $stable(slot_q[i]));
  end

  assign rd_a_valid_o = slot_q[rd_a_idx_i].valid;
  assign rd_a_vbase_o = slot_q[rd_a_idx_i].vbase;
  assign rd_a_pbase_o = slot_q[rd_a_idx_i].pbase;
  assign rd_a_size_o  = slot_q[rd_a_idx_i].size;
  assign rd_b_valid_o = slot_q[rd_b_idx_i].valid;
  assign rd_b_vbase_o = slot_q[rd_b_idx_i].vbase;
  assign rd_b_pbase_o = slot_q[rd_b_idx_i].pbase;
  assign rd_b_size_o  = slot_q[rd_b_idx_i].size;
endmodule

// File: rtl/range_xlate_match.sv
module range_xlate_match #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned LEN_W  = 16
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] vbase_i,
  input  logic [ADDR_W-1:0] pbase_i,
  input  logic [ADDR_W-1:0] size_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [LEN_W-1:0]  last_i,
  output logic              hit_o,
  output logic              cross_o,
  output logic [ADDR_W-1:0] pa_o
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W:0]   end_off;

  always_comb begin
    off     = va_i - vbase_i;
    // offset kept one bit wider so a burst near the top of space cannot wrap
    end_off = {1'b0, off} + {{(ADDR_W+1-LEN_W){1'b0}}, last_i};
    hit_o   = valid_i && (va_i >= vbase_i) && (off < size_i);
    cross_o = end_off >= {1'b0, size_i};
    pa_o    = pbase_i + off;
  end
endmodule

// File: rtl/range_xlate.sv
module range_xlate
  import range_xlate_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 16,
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned LEN_W       = 16,
  localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_priv_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic [ADDR_W-1:0] cfg_vbase_i,
  input  logic [ADDR_W-1:0] cfg_pbase_i,
  input  logic [ADDR_W-1:0] cfg_size_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic [LEN_W-1:0]  req_last_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_pa_o,
  output logic [1:0]        rsp_fault_o
);
  localparam int unsigned CNT_W = IDX_W + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [CNT_W-1:0] ALL_CNT  = CNT_W'(NUM_ENTRIES);
  localparam logic [CNT_W-1:0] REST_CNT = CNT_W'(NUM_ENTRIES - 1);

  state_e            state_q;
  logic [ADDR_W-1:0] va_q;
  logic [LEN_W-1:0]  last_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  cur_q;
  logic              cur_vld_q;

  logic              acc, cfg_wr;
  logic              c_valid, s_valid;
  logic [ADDR_W-1:0] c_vbase, c_pbase, c_size;
  logic [ADDR_W-1:0] s_vbase, s_pbase, s_size;
  logic              c_hit, c_cross, s_hit, s_cross;
  logic [ADDR_W-1:0] c_pa, s_pa;
  logic [IDX_W-1:0]  cur_next;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  assign req_ready_o = (state_q == ST_IDLE);
  assign acc         = req_valid_i && req_ready_o;
  assign cfg_wr      = cfg_we_i && cfg_priv_i;
  assign cur_next    = wrap_inc(cur_q);

  range_xlate_table #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ADDR_W      (ADDR_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (cfg_we_i),
    .wr_priv_i    (cfg_priv_i),
    .wr_idx_i     (cfg_idx_i),
    .wr_valid_i   (cfg_valid_i),
    .wr_vbase_i   (cfg_vbase_i),
    .wr_pbase_i   (cfg_pbase_i),
    .wr_size_i    (cfg_size_i),
    .rd_a_idx_i   (cur_q),
    .rd_a_valid_o (c_valid),
    .rd_a_vbase_o (c_vbase),
    .rd_a_pbase_o (c_pbase),
    .rd_a_size_o  (c_size),
    .rd_b_idx_i   (ptr_q),
    .rd_b_valid_o (s_valid),
    .rd_b_vbase_o (s_vbase),
    .rd_b_pbase_o (s_pbase),
    .rd_b_size_o  (s_size)
  );

  range_xlate_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_cur_match (
    .valid_i (c_valid),
    .vbase_i (c_vbase),
    .pbase_i (c_pbase),
    .size_i  (c_size),
    .va_i    (req_va_i),
    .last_i  (req_last_i),
    .hit_o   (c_hit),
    .cross_o (c_cross),
    .pa_o    (c_pa)
  );

  range_xlate_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_scan_match (
    .valid_i (s_valid),
    .vbase_i (s_vbase),
    .pbase_i (s_pbase),
    .size_i  (s_size),
    .va_i    (va_q),
    .last_i  (last_q),
    .hit_o   (s_hit),
    .cross_o (s_cross),
    .pa_o    (s_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      last_q      <= '0;
      ptr_q       <= '0;
      cnt_q       <= '0;
      cur_q       <= '0;
      cur_vld_q   <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_pa_o    <= '0;
      rsp_fault_o <= FLT_OK;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (acc) begin
            if (cur_vld_q && c_hit) begin
              rsp_valid_o <= 1'b1;
              rsp_fault_o <= c_cross ? FLT_CROSS : FLT_OK;
              rsp_pa_o    <= c_cross ? '0 : c_pa;
            end else begin
              state_q <= ST_SCAN;
              va_q    <= req_va_i;
              last_q  <= req_last_i;
              ptr_q   <= cur_vld_q ? cur_next : '0;
              cnt_q   <= cur_vld_q ? REST_CNT : ALL_CNT;
            end
          end
        end
        ST_SCAN: begin
          if (s_hit) begin
            state_q     <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= s_cross ? FLT_CROSS : FLT_OK;
            rsp_pa_o    <= s_cross ? '0 : s_pa;
            if (!s_cross) begin
              cur_q     <= ptr_q;
              cur_vld_q <= 1'b1;
            end
          end else if (cnt_q <= CNT_W'(1)) begin
            state_q     <= ST_IDLE;
            rsp_valid_o <= 1'b1;
            rsp_fault_o <= FLT_NOHIT;
            rsp_pa_o    <= '0;
          end else begin
            ptr_q <= wrap_inc(ptr_q);
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      // table changes drop the cursor; takes priority over a walk hit
      if (cfg_wr) cur_vld_q <= 1'b0;
    end
  end

  p_cur_hit_lat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cur_vld_q && c_hit) |=> rsp_valid_o);

  p_scan_cnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN) |-> (cnt_q != '0 && cnt_q <= ALL_CNT));

  p_cursor_move_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && s_hit && !s_cross && !cfg_wr) |=>
      (cur_vld_q && cur_q == $past(ptr_q)));

  p_priv_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> !cur_vld_q);

  p_rsp_origin_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> ($past(acc) || $past(state_q == ST_SCAN)));

  p_cross_no_cursor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && s_hit && s_cross) |=> $stable(cur_q));
endmodule

// File: tb/range_xlate_bench.sv
module range_xlate_bench;
  localparam int N  = 16;
  localparam int AW = 48;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_priv = 1'b0, cfg_valid = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_vbase = '0, cfg_pbase = '0, cfg_size = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_va = '0;
  logic [LW-1:0] req_last = '0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_pa;
  logic [1:0]    rsp_fault;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  range_xlate u_range_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_idx_i(cfg_idx),
    .cfg_valid_i(cfg_valid), .cfg_vbase_i(cfg_vbase), .cfg_pbase_i(cfg_pbase),
    .cfg_size_i(cfg_size),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_last_i(req_last),
    .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa), .rsp_fault_o(rsp_fault)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit priv, input int idx, input bit v,
                    input logic [AW-1:0] vb, input logic [AW-1:0] pb,
                    input logic [AW-1:0] sz);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_idx = 4'(idx); cfg_valid = v;
    cfg_vbase = vb; cfg_pbase = pb; cfg_size = sz;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
  endtask

  // issue one burst, return pa, fault, latency and whether ready stayed low while busy
  task automatic xl(input logic [AW-1:0] va, input logic [LW-1:0] last,
                    output logic [AW-1:0] pa, output logic [1:0] flt,
                    output int lat, output bit busy_ok);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_last = last;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_ok = 1'b1;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk);
      lat++;
    end
    pa = rsp_pa; flt = rsp_fault;
  endtask

  task automatic expect_x(input string req, input logic [AW-1:0] va,
                          input logic [LW-1:0] last, input logic [AW-1:0] epa,
                          input logic [1:0] eflt, input int elat);
    logic [AW-1:0] pa; logic [1:0] f; int lat; bit b;
    xl(va, last, pa, f, lat, b);
    chk(lat == elat, req, "latency", 64'(lat), 64'(elat));
    chk(f == eflt, req, "fault", 64'(f), 64'(eflt));
    chk(pa == epa, req, "pa", 64'(pa), 64'(epa));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 1);
  endtask

  task automatic t_load();
    wr(1, 0, 1, 48'h1000_0000, 48'h8_0000_0000, 48'h1_0000);
    wr(1, 3, 1, 48'h2000_0000, 48'h0_4000_0000, 48'h4000);
    wr(1, 7, 1, 48'h3000_0000, 48'h123_0000_0000, 48'h1000);
    wr(1, 15, 1, 48'h4000_0000, 48'h10_0000, 48'h10_0000);
  endtask

  task automatic t_cold_walk();
    logic [AW-1:0] pa; logic [1:0] f; int lat; bit b;
    // R1/R4: no cursor, walk 0..3 -> k=4
    xl(48'h2000_0100, 16'h3f, pa, f, lat, b);
    chk(lat == 5, "R4", "cold walk latency", 64'(lat), 5);
    chk(pa == 48'h4000_0100, "R2", "pa", 64'(pa), 64'h4000_0100);
    chk(f == 2'b00, "R2", "fault", 64'(f), 0);
    chk(b, "R9", "ready low during walk", 64'(b), 1);
  endtask

  task automatic t_cursor_hit();
    expect_x("R3", 48'h2000_0200, 16'h3f, 48'h4000_0200, 2'b00, 1);
  endtask

  task automatic t_wrap();
    expect_x("R4", 48'h1000_0abc, 16'h0, 48'h8_0000_0abc, 2'b00, 14); // 4..15,0
    expect_x("R4", 48'h4000_0010, 16'h0, 48'h10_0010, 2'b00, 16);     // 1..15
    expect_x("R4", 48'h3000_0004, 16'h7, 48'h123_0000_0004, 2'b00, 9); // 0..7
    expect_x("R3", 48'h3000_0008, 16'h7, 48'h123_0000_0008, 2'b00, 1);
  endtask

  task automatic t_nomatch();
    // R5: va just past slot 7's end; cursor miss then 15 others
    expect_x("R5", 48'h3000_1000, 16'h0, 48'h0, 2'b01, 16);
    expect_x("R5", 48'h3000_0010, 16'h0, 48'h123_0000_0010, 2'b00, 1);
  endtask

  task automatic t_cross();
    expect_x("R6", 48'h3000_0f00, 16'hff, 48'h123_0000_0f00, 2'b00, 1);
    expect_x("R6", 48'h3000_0f00, 16'h100, 48'h0, 2'b10, 1);
    expect_x("R6", 48'h2000_3ff0, 16'h10, 48'h0, 2'b10, 13); // 8..15,0..3
    expect_x("R6", 48'h3000_0020, 16'h0, 48'h123_0000_0020, 2'b00, 1);
  endtask

  task automatic t_unpriv();
    wr(0, 7, 1, 48'h3000_0000, 48'h999_0000_0000, 48'h1000);
    expect_x("R7", 48'h3000_0030, 16'h0, 48'h123_0000_0030, 2'b00, 1);
  endtask

  task automatic t_priv_drop();
    wr(1, 9, 0, 48'h0, 48'h0, 48'h0);
    expect_x("R8", 48'h3000_0040, 16'h0, 48'h123_0000_0040, 2'b00, 9);
  endtask

  task automatic t_invalid_slot();
    wr(1, 5, 0, 48'h5000_0000, 48'h77_0000, 48'h1000);
    expect_x("R10", 48'h5000_0000, 16'h0, 48'h0, 2'b01, 17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_cold_walk();
    t_cursor_hit();
    t_wrap();
    t_nomatch();
    t_cross();
    t_unpriv();
    t_priv_drop();
    t_invalid_slot();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule